// File: doc/BRIEF.md
# Virtual Link Credit Policer

This block checks incoming frames against a per-link bandwidth contract before they are admitted to a switching stage. Each virtual link owns a token bucket of byte credit. The bucket is not programmed directly. Software writes three values per link: the largest frame the link may carry, the minimum spacing in ticks between two frames (the allocation gap), and the jitter the link is allowed. From these the block derives the fill rate and the bucket depth.

On every pulse of a free-running time tick, each configured link gains credit equal to its maximum frame length divided by its gap. That credit is kept in fixed point with 8 fractional bits. Credit stops growing once the bucket is full. A frame arrival presents a link number and a byte length. One cycle later the block answers with pass or drop. A passing frame spends its length in credit. Every drop adds one to that link's drop counter. Each hop in a network places one of these ahead of its switch.

Top module: `vl_policer`

## Requirements
- R1: After reset no verdict is flagged, every drop counter reads zero, and every link is unconfigured, so any frame is dropped.
- R2: A configuration write with a nonzero maximum length and a nonzero gap makes the link configured and fills its bucket to capacity. A write with either value zero makes the link unconfigured. The write applies on the next clock edge.
- R3: Bucket capacity in bytes is maxlen + floor(maxlen * jitter / gap). A burst of back-to-back frames whose lengths add up to no more than the capacity all pass when the bucket is full.
- R4: Each cycle with tick high adds floor(maxlen * 256 / gap) to a configured link's credit, counted in 1/256-byte units. Credit never exceeds the capacity.
- R5: A frame passes only when its link is configured, its length is at most the link's maximum length, and the link's credit is at least length * 256 units.
- R6: A passing frame removes length * 256 units from its link's credit. A dropped frame leaves the credit unchanged.
- R7: The verdict_valid output is high in exactly the cycle after each arrival strobe. verdict_pass is meaningful only then, and it is low whenever verdict_valid is low.
- R8: Every dropped frame adds one, with wraparound, to the 16-bit counter of its own link. Link k occupies bits [16k+15:16k] of drop_count. Other links' counters do not change.
- R9: A frame for an unconfigured link, or a frame longer than its link's maximum length, is always dropped, whatever the credit.
- R10: When a tick and an arrival fall in the same cycle, the verdict uses the credit held before that tick. Both the refill and the deduction are then applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_link | input | LINK_W | Link being configured |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes |
| cfg_gap | input | GAP_W | Allocation gap in ticks |
| cfg_jitter | input | JIT_W | Allowed jitter in ticks |
| tick | input | 1 | Refill time tick |
| arr_valid | input | 1 | Frame arrival strobe |
| arr_link | input | LINK_W | Link of the arriving frame |
| arr_len | input | LEN_W | Length of the arriving frame in bytes |
| verdict_valid | output | 1 | Verdict present, one cycle after arrival |
| verdict_pass | output | 1 | 1 = frame admitted, 0 = dropped |
| drop_count | output | NUM_LINKS*CNT_W | Per-link drop counters, link k in bits [16k+15:16k] |

## Verification
The bench builds the block with its default parameters: four links, 11-bit lengths, 8-bit gap and jitter, and 8 fractional bits. This lets a single run configure three links with different gap and jitter ratios and leave one unconfigured. The gaps of 3, 4 and 8 give both exact and truncated fractional refill rates. With jitter 8 over a gap of 8, the bucket holds two full-size frames, so a burst over the single-frame limit can be shown to pass. A later write takes one link from unconfigured to configured, and another write unconfigures a link, which covers both directions of R2 in mid-traffic.

// File: rtl/vl_policer.sv
module vl_policer #(
  parameter int NUM_LINKS = 4,
  parameter int LEN_W     = 11,
  parameter int GAP_W     = 8,
  parameter int JIT_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int CNT_W     = 16,
  localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int CAP_W    = LEN_W + JIT_W + 1,
  localparam int CRED_W   = CAP_W + FRAC_W,
  localparam int RATE_W   = LEN_W + FRAC_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [LINK_W-1:0]            cfg_link,
  input  logic [LEN_W-1:0]             cfg_max_len,
  input  logic [GAP_W-1:0]             cfg_gap,
  input  logic [JIT_W-1:0]             cfg_jitter,
  input  logic                         tick,
  input  logic                         arr_valid,
  input  logic [LINK_W-1:0]            arr_link,
  input  logic [LEN_W-1:0]             arr_len,
  output logic                         verdict_valid,
  output logic                         verdict_pass,
  output logic [NUM_LINKS*CNT_W-1:0]   drop_count
);

  logic              lnk_on   [NUM_LINKS];
  logic [LEN_W-1:0]  lnk_max  [NUM_LINKS];
  logic [RATE_W-1:0] lnk_rate [NUM_LINKS];
  logic [CRED_W-1:0] lnk_cap  [NUM_LINKS];
  logic [CRED_W-1:0] credit   [NUM_LINKS];
  logic [CRED_W-1:0] credit_d [NUM_LINKS];
  logic [CNT_W-1:0]  drops    [NUM_LINKS];

  logic                     cfg_ok;
  logic [GAP_W-1:0]         gap_div;
  logic [LEN_W+JIT_W-1:0]   slack;
  logic [CAP_W-1:0]         cap_bytes;
  logic [RATE_W-1:0]        rate_new;

  assign cfg_ok    = (cfg_max_len != '0) && (cfg_gap != '0);
  assign gap_div   = (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;
  assign slack     = (LEN_W+JIT_W)'(cfg_max_len) * (LEN_W+JIT_W)'(cfg_jitter)
                     / (LEN_W+JIT_W)'(gap_div);
  assign cap_bytes = CAP_W'(cfg_max_len) + CAP_W'(slack);
  assign rate_new  = {cfg_max_len, {FRAC_W{1'b0}}} / RATE_W'(gap_div);

  logic [CRED_W-1:0] len_fx;
  logic              admit;

  assign len_fx = CRED_W'({arr_len, {FRAC_W{1'b0}}});
  assign admit  = lnk_on[arr_link] && (arr_len <= lnk_max[arr_link])
                  && (credit[arr_link] >= len_fx);

  always_comb begin
    for (int i = 0; i < NUM_LINKS; i++) begin
      logic [CRED_W:0] sum;
      sum = {1'b0, credit[i]};
      if (arr_valid && admit && arr_link == LINK_W'(i))
        sum = sum - {1'b0, len_fx};
      if (tick && lnk_on[i])
        sum = sum + (CRED_W+1)'(lnk_rate[i]);
      credit_d[i] = (sum > {1'b0, lnk_cap[i]}) ? lnk_cap[i] : sum[CRED_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_pass  <= 1'b0;
      for (int i = 0; i < NUM_LINKS; i++) begin
        lnk_on[i]   <= 1'b0;
        lnk_max[i]  <= '0;
        lnk_rate[i] <= '0;
        lnk_cap[i]  <= '0;
        credit[i]   <= '0;
        drops[i]    <= '0;
      end
    end else begin
      verdict_valid <= arr_valid;
      verdict_pass  <= arr_valid && admit;
      for (int i = 0; i < NUM_LINKS; i++) begin
        if (arr_valid && !admit && arr_link == LINK_W'(i))
          drops[i] <= drops[i] + 1'b1;
        if (cfg_we && cfg_link == LINK_W'(i)) begin
          lnk_on[i]   <= cfg_ok;
          lnk_max[i]  <= cfg_max_len;
          lnk_rate[i] <= cfg_ok ? rate_new : '0;
          lnk_cap[i]  <= cfg_ok ? {cap_bytes, {FRAC_W{1'b0}}} : '0;
          credit[i]   <= cfg_ok ? {cap_bytes, {FRAC_W{1'b0}}} : '0;
        end else begin
          credit[i]   <= credit_d[i];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_cnt
    assign drop_count[g*CNT_W +: CNT_W] = drops[g];
  end

endmodule

// File: rtl/vl_policer_chk.sv
module vl_policer_chk #(
  parameter int NUM_LINKS = 4,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 16,
  parameter int CRED_W    = 28,
  parameter int LINK_W    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       arr_valid,
  input logic [LINK_W-1:0]          arr_link,
  input logic [LEN_W-1:0]           arr_len,
  input logic                       verdict_valid,
  input logic                       verdict_pass,
  input logic [NUM_LINKS*CNT_W-1:0] drop_count,
  input logic [CRED_W-1:0]          credit  [NUM_LINKS],
  input logic [CRED_W-1:0]          lnk_cap [NUM_LINKS],
  input logic                       lnk_on  [NUM_LINKS],
  input logic [LEN_W-1:0]           lnk_max [NUM_LINKS]
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_verdict_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (verdict_valid == $past(arr_valid)));

  assert_pass_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_pass |-> verdict_valid);

  assert_pass_rules_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && verdict_pass) |->
      ($past(lnk_on[arr_link]) && ($past(arr_len) <= $past(lnk_max[arr_link]))));

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lnk
    assert_credit_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      credit[g] <= lnk_cap[g]);

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |->
        ((drop_count[g*CNT_W +: CNT_W] == $past(drop_count[g*CNT_W +: CNT_W])) ||
         (drop_count[g*CNT_W +: CNT_W] == $past(drop_count[g*CNT_W +: CNT_W]) + 1'b1)));
  end

endmodule

bind vl_policer vl_policer_chk #(
  .NUM_LINKS(NUM_LINKS), .LEN_W(LEN_W), .CNT_W(CNT_W), .CRED_W(CRED_W), .LINK_W(LINK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_link(arr_link),
  .arr_len(arr_len), .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
  .drop_count(drop_count), .credit(credit), .lnk_cap(lnk_cap),
  .lnk_on(lnk_on), .lnk_max(lnk_max)
);

// File: tb/sim_vl_policer.sv
module sim_vl_policer;
  localparam int NL = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_link = '0;
  logic [10:0] cfg_max_len = '0;
  logic [7:0] cfg_gap = '0, cfg_jitter = '0;
  logic tick = 1'b0, arr_valid = 1'b0;
  logic [1:0] arr_link = '0;
  logic [10:0] arr_len = '0;
  logic verdict_valid, verdict_pass;
  logic [NL*CW-1:0] drop_count;

  always #2 clk = ~clk;

  vl_policer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_link(cfg_link),
    .cfg_max_len(cfg_max_len), .cfg_gap(cfg_gap), .cfg_jitter(cfg_jitter),
    .tick(tick), .arr_valid(arr_valid), .arr_link(arr_link), .arr_len(arr_len),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass), .drop_count(drop_count)
  );

  int compared = 0, mismatched = 0;
  longint m_on[NL], m_max[NL], m_rate[NL], m_cap[NL], m_cred[NL], m_drop[NL];
  logic pend = 1'b0, pend_pass = 1'b0;
  string pend_req = "R5";

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic m_admit(input int l, input longint len);
    return (m_on[l] != 0) && (len <= m_max[l]) && (m_cred[l] >= len * 256);
  endfunction

  task automatic cfg(input int l, input int ml, input int gp, input int jt);
    @(negedge clk);
    if (pend) begin chk(pend_req, verdict_pass, pend_pass); chk("R7", verdict_valid, 1); end
    pend = 1'b0;
    cfg_we = 1'b1; cfg_link = 2'(l); cfg_max_len = 11'(ml); cfg_gap = 8'(gp); cfg_jitter = 8'(jt);
    tick = 1'b0; arr_valid = 1'b0;
    m_on[l] = (ml != 0 && gp != 0);
    m_max[l] = ml;
    m_rate[l] = m_on[l] ? (longint'(ml) * 256) / gp : 0;
    m_cap[l] = m_on[l] ? (ml + (longint'(ml) * jt) / gp) * 256 : 0;
    m_cred[l] = m_cap[l];
  endtask

  task automatic step(input bit t, input bit a, input int l, input int len, input string req);
    @(negedge clk);
    if (pend) begin chk(pend_req, verdict_pass, pend_pass); chk("R7", verdict_valid, 1); end
    else chk("R7", verdict_valid, 0);
    cfg_we = 1'b0; tick = t; arr_valid = a; arr_link = 2'(l); arr_len = 11'(len);
    pend = a; pend_req = req;
    if (a) begin
      pend_pass = m_admit(l, len);
      if (pend_pass) m_cred[l] -= longint'(len) * 256;
      else m_drop[l] = (m_drop[l] + 1) % 65536;
    end
    if (t) for (int i = 0; i < NL; i++)
      if (m_on[i] != 0) begin
        m_cred[i] += m_rate[i];
        if (m_cred[i] > m_cap[i]) m_cred[i] = m_cap[i];
      end
  endtask

  task automatic chk_drops(input string req);
    for (int i = 0; i < NL; i++) chk(req, drop_count[i*CW +: CW], m_drop[i]);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin
      m_on[i] = 0; m_max[i] = 0; m_rate[i] = 0; m_cap[i] = 0; m_cred[i] = 0; m_drop[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", verdict_valid, 0);
    chk("R1", drop_count, 0);
    rst_n = 1'b1;
    step(0, 1, 2, 10, "R1");
    step(0, 0, 0, 0, "R1");
    chk_drops("R1");

    cfg(0, 100, 4, 0);
    cfg(1, 64, 8, 8);
    cfg(2, 200, 3, 1);
    step(0, 1, 1, 64, "R3");
    step(0, 1, 1, 64, "R3");
    step(0, 1, 1, 1, "R6");
    step(0, 1, 3, 5, "R9");
    step(0, 1, 0, 101, "R9");
    step(0, 1, 0, 100, "R2");
    step(0, 1, 0, 25, "R6");
    step(1, 1, 0, 25, "R10");
    step(0, 1, 0, 25, "R4");
    repeat (10) step(1, 0, 0, 0, "R4");
    step(0, 1, 1, 64, "R4");
    step(0, 1, 1, 64, "R4");
    step(0, 1, 1, 1, "R4");
    step(0, 0, 0, 0, "R8");
    chk_drops("R8");

    for (int n = 0; n < 3000; n++) begin
      int l, len;
      l = int'($urandom_range(0, 3));
      len = int'($urandom_range(1, 210));
      if (n == 1000) cfg(3, 40, 2, 3);
      if (n == 2000) cfg(2, 0, 3, 1);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, l, len, "R5");
    end
    step(0, 0, 0, 0, "R8");
    chk_drops("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule